// File: doc/BRIEF.md
# Dual-Bus Sample Input Formatter

This block sits at the front of a transmit datapath and turns two 16-bit parallel sample buses, A and B, into one valid-qualified I/Q pair per data clock. Bus B can be taken with its bit order reversed. Words in offset binary can be converted to two's complement. A built-in ramp counter can take the place of the input data as a test source.

In straight mode, bus A carries I and bus B carries Q in the same cycle. In interleave mode, both I and Q arrive on bus A and are paired up. Two schemes mark which word is which. In edge mode, the first word after transmit enable goes high is I and the words then alternate. In flag mode, a per-word Q flag marks each word. While transmit enable is low, the block drives a midscale (zero) output with valid low. All controls are sampled on the clock edge together with the data, so a mode change applies to the word sampled on that same edge.

Top module: `dual_bus_fmt`

## Requirements
- R1: In straight mode (`ilv_i` low), for every cycle with `txen_i` high, the next cycle shows the formatted bus A word on `i_o`, the formatted bus B word on `q_o`, and `valid_o` high. The latency is one clock.
- R2: With `twos_comp_i` low, a word is taken as offset binary and its bit 15 is inverted. With `twos_comp_i` high, the word passes unchanged.
- R3: With `rev_b_i` high, bus B bit k lands in bit 15-k before format conversion. With `rev_b_i` low, bus B keeps its bit order. Bus A is never reversed.
- R4: In edge mode (`ilv_i` high, `qflag_mode_i` low), only bus A is used. The first word sampled with `txen_i` high after a cycle with it low (or after reset) is I, and the words then alternate Q, I, Q and so on. Each Q word produces a valid pair, made of the I word just before it and that Q word, in the next cycle.
- R5: In flag mode (`ilv_i` high, `qflag_mode_i` high), a bus A word sampled with `qflag_i` high is Q and one sampled with it low is I. A Q word with no stored I is dropped. A second I word replaces the stored one.
- R6: A cycle with `txen_i` low gives `valid_o` low and zero on both outputs in the next cycle. It also discards any stored I word and holds the ramp counter.
- R7: Whenever `valid_o` is low, `i_o` and `q_o` are both zero. This includes the state after reset.
- R8: With `ramp_i` high, a 16-bit counter replaces the data of both buses and is not affected by reversal or conversion. The counter is 0 on the first cycle with `txen_i` high after `ramp_i` rises. It increments on each cycle with `txen_i` high, wraps from 65535 to 0, and drives the same value on both channels.
- R9: Controls apply to the word sampled on the same edge. Leaving interleave mode discards a stored I word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_a_i | input | 16 | Sample bus A |
| bus_b_i | input | 16 | Sample bus B |
| txen_i | input | 1 | Transmit enable |
| qflag_i | input | 1 | Per-word Q marker, used in flag mode |
| twos_comp_i | input | 1 | 1: input is two's complement, 0: offset binary |
| rev_b_i | input | 1 | Reverse the bit order of bus B |
| ilv_i | input | 1 | Interleaved I/Q on bus A |
| qflag_mode_i | input | 1 | Alignment by Q flag (1) or by enable edge (0) |
| ramp_i | input | 1 | Replace input data with the ramp counter |
| i_o | output | 16 | I sample |
| q_o | output | 16 | Q sample |
| valid_o | output | 1 | I/Q pair valid |

## Verification
The bench targets the pairing corner cases.
- A Q word arriving first in flag mode must be dropped. A design that pairs it with a stale I would emit a spurious pair.
- An I stored when transmit enable falls, or when interleave mode is left, must not pair with a later Q. Stale pending state would show up as an extra valid.
- Edge-mode restarts after a gap must begin on I. A phase register that is not cleared would swap the I and Q lanes.

It also checks the full sign-bit and bit-reversal patterns (0x0000, 0x8000, 0xFFFF, single bits) and a ramp run across the 65535-to-0 wrap. The wrap would expose a counter that saturates or that is run through the offset-binary conversion.

// File: rtl/dual_bus_fmt_pkg.sv
package dual_bus_fmt_pkg;
  parameter int unsigned WORD_W = 16;

  typedef enum logic {SLOT_I = 1'b0, SLOT_Q = 1'b1} slot_e;

  typedef struct packed {
    logic [WORD_W-1:0] i;
    logic [WORD_W-1:0] q;
  } iq_pair_t;
endpackage

// File: rtl/dfmt_src.sv
module dfmt_src #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bus_a_i,
  input  logic [W-1:0] bus_b_i,
  input  logic         txen_i,
  input  logic         ramp_i,
  input  logic         rev_b_i,
  output logic [W-1:0] word_a_o,
  output logic [W-1:0] word_b_o,
  output logic         ramp_sel_o
);
  logic [W-1:0] ramp_q;
  logic [W-1:0] b_rev;

  for (genvar k = 0; k < W; k++) begin : g_rev
    assign b_rev[k] = bus_b_i[W-1-k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ramp_q <= '0;
    else if (!ramp_i) ramp_q <= '0;
    else if (txen_i)  ramp_q <= ramp_q + W'(1);
  end

  always_comb begin
    if (ramp_i) begin
      word_a_o = ramp_q;
      word_b_o = ramp_q;
    end else begin
      word_a_o = bus_a_i;
      word_b_o = rev_b_i ? b_rev : bus_b_i;
    end
  end

  assign ramp_sel_o = ramp_i;
endmodule

// File: rtl/dfmt_conv.sv
module dfmt_conv #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] word_i,
  input  logic         twos_comp_i,
  input  logic         bypass_i,
  output logic [W-1:0] word_o
);
  logic flip;
  assign flip   = !twos_comp_i && !bypass_i;
  assign word_o = {word_i[W-1] ^ flip, word_i[W-2:0]};
endmodule

// File: rtl/dfmt_pair.sv
module dfmt_pair
  import dual_bus_fmt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_a_i,
  input  logic [W-1:0] word_b_i,
  input  logic         txen_i,
  input  logic         ilv_i,
  input  logic         qflag_mode_i,
  input  logic         qflag_i,
  output logic [W-1:0] i_o,
  output logic [W-1:0] q_o,
  output logic         valid_o
);
  logic [W-1:0] pend_q, pend_d;
  logic         pend_vld_q, pend_vld_d;
  slot_e        phase_q, phase_d, slot;
  logic [W-1:0] i_d, q_d;
  logic         vld_d;

  assign slot = qflag_mode_i ? slot_e'(qflag_i) : phase_q;

  always_comb begin
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    phase_d    = SLOT_I;
    i_d        = '0;
    q_d        = '0;
    vld_d      = 1'b0;
    if (!txen_i || !ilv_i) begin
      pend_vld_d = 1'b0;
      if (txen_i) begin
        i_d   = word_a_i;
        q_d   = word_b_i;
        vld_d = 1'b1;
      end
    end else begin
      if (!qflag_mode_i) phase_d = (phase_q == SLOT_I) ? SLOT_Q : SLOT_I;
      if (slot == SLOT_Q) begin
        if (pend_vld_q) begin
          i_d        = pend_q;
          q_d        = word_a_i;
          vld_d      = 1'b1;
          pend_vld_d = 1'b0;
        end
      end else begin
        pend_d     = word_a_i;
        pend_vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      phase_q    <= SLOT_I;
      i_o        <= '0;
      q_o        <= '0;
      valid_o    <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
      phase_q    <= phase_d;
      i_o        <= i_d;
      q_o        <= q_d;
      valid_o    <= vld_d;
    end
  end
endmodule

// File: rtl/dual_bus_fmt.sv
module dual_bus_fmt #(
  parameter int unsigned DATA_W = dual_bus_fmt_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] bus_a_i,
  input  logic [DATA_W-1:0] bus_b_i,
  input  logic              txen_i,
  input  logic              qflag_i,
  input  logic              twos_comp_i,
  input  logic              rev_b_i,
  input  logic              ilv_i,
  input  logic              qflag_mode_i,
  input  logic              ramp_i,
  output logic [DATA_W-1:0] i_o,
  output logic [DATA_W-1:0] q_o,
  output logic              valid_o
);
  localparam int unsigned NLANE = 2;

  logic [DATA_W-1:0] src_w [NLANE];
  logic [DATA_W-1:0] fmt_w [NLANE];
  logic              ramp_sel;

  dfmt_src #(.W(DATA_W)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_a_i    (bus_a_i),
    .bus_b_i    (bus_b_i),
    .txen_i     (txen_i),
    .ramp_i     (ramp_i),
    .rev_b_i    (rev_b_i),
    .word_a_o   (src_w[0]),
    .word_b_o   (src_w[1]),
    .ramp_sel_o (ramp_sel)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    dfmt_conv #(.W(DATA_W)) u_conv (
      .word_i      (src_w[l]),
      .twos_comp_i (twos_comp_i),
      .bypass_i    (ramp_sel),
      .word_o      (fmt_w[l])
    );
  end

  dfmt_pair #(.W(DATA_W)) u_pair (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_a_i     (fmt_w[0]),
    .word_b_i     (fmt_w[1]),
    .txen_i       (txen_i),
    .ilv_i        (ilv_i),
    .qflag_mode_i (qflag_mode_i),
    .qflag_i      (qflag_i),
    .i_o          (i_o),
    .q_o          (q_o),
    .valid_o      (valid_o)
  );
endmodule

// File: rtl/dual_bus_fmt_chk.sv
module dual_bus_fmt_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] bus_a_i,
  input logic         txen_i,
  input logic         qflag_i,
  input logic         twos_comp_i,
  input logic         ilv_i,
  input logic         qflag_mode_i,
  input logic         ramp_i,
  input logic [W-1:0] i_o,
  input logic [W-1:0] q_o,
  input logic         valid_o
);
  AST_STRAIGHT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txen_i && !ilv_i) |=> valid_o); // R1

  AST_OFFSET_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txen_i && !ilv_i && !ramp_i && !twos_comp_i) |=>
      (i_o == {~$past(bus_a_i[W-1]), $past(bus_a_i[W-2:0])})); // R2

  AST_EDGE_FIRST_I: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(txen_i) && ilv_i && !qflag_mode_i) |=> !valid_o); // R4

  AST_FLAG_LOW_NOPAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txen_i && ilv_i && qflag_mode_i && !qflag_i) |=> !valid_o); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txen_i |=> (!valid_o && i_o == '0 && q_o == '0)); // R6

  AST_INVALID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (i_o == '0 && q_o == '0)); // R7

  AST_RAMP_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_i && txen_i && !ilv_i) |=> (i_o == q_o)); // R8

  AST_RAMP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_i && txen_i && !ilv_i) ##1 (ramp_i && txen_i && !ilv_i) |=>
      ((i_o - $past(i_o)) == W'(1))); // R8
endmodule

bind dual_bus_fmt dual_bus_fmt_chk #(.W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_a_i      (bus_a_i),
  .txen_i       (txen_i),
  .qflag_i      (qflag_i),
  .twos_comp_i  (twos_comp_i),
  .ilv_i        (ilv_i),
  .qflag_mode_i (qflag_mode_i),
  .ramp_i       (ramp_i),
  .i_o          (i_o),
  .q_o          (q_o),
  .valid_o      (valid_o)
);

// File: tb/dual_bus_fmt_tb.sv
module dual_bus_fmt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_a = '0, bus_b = '0;
  logic        txen = 1'b0, qflag = 1'b0, twos = 1'b0, rev_b = 1'b0;
  logic        ilv = 1'b0, qmode = 1'b0, ramp = 1'b0;
  logic [15:0] i_o, q_o;
  logic        valid_o;

  int checks = 0;
  int failures = 0;
  string cur_req = "R7";

  // reference model state
  logic [15:0] pend[$];
  int          cnt = 0;
  bit          phase = 0;
  logic [15:0] exp_i = '0, exp_q = '0;
  logic        exp_v = 1'b0;

  always #2 clk = ~clk;

  dual_bus_fmt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_a_i(bus_a), .bus_b_i(bus_b),
    .txen_i(txen), .qflag_i(qflag), .twos_comp_i(twos), .rev_b_i(rev_b),
    .ilv_i(ilv), .qflag_mode_i(qmode), .ramp_i(ramp),
    .i_o(i_o), .q_o(q_o), .valid_o(valid_o)
  );

  function automatic logic [15:0] fmt(input logic [15:0] w);
    return twos ? w : (w ^ 16'h8000);
  endfunction

  function automatic logic [15:0] revw(input logic [15:0] w);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = w[15-k];
    return r;
  endfunction

  task automatic model();
    logic [15:0] wa, wb;
    bit isq;
    if (ramp) begin
      wa = 16'(cnt); wb = 16'(cnt);
      if (txen) cnt = (cnt + 1) % 65536;
    end else begin
      cnt = 0;
      wa = fmt(bus_a);
      wb = fmt(rev_b ? revw(bus_b) : bus_b);
    end
    exp_i = '0; exp_q = '0; exp_v = 1'b0;
    if (!txen || !ilv) begin
      pend.delete();
      phase = 0;
      if (txen) begin exp_i = wa; exp_q = wb; exp_v = 1'b1; end
    end else begin
      isq = qmode ? qflag : phase;
      phase = qmode ? 1'b0 : ~phase;
      if (isq) begin
        if (pend.size() > 0) begin
          exp_i = pend[0]; exp_q = wa; exp_v = 1'b1;
          pend.delete();
        end
      end else begin
        pend.delete();
        pend.push_back(wa);
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (valid_o !== exp_v || i_o !== exp_i || q_o !== exp_q) begin
      failures++;
      $display("FAIL %s: act v=%0b i=%h q=%h exp v=%0b i=%h q=%h",
               cur_req, valid_o, i_o, q_o, exp_v, exp_i, exp_q);
    end
  endtask

  task automatic cyc(input logic [15:0] a, input logic [15:0] b,
                     input logic tx, input logic qf);
    @(negedge clk);
    bus_a = a; bus_b = b; txen = tx; qflag = qf;
    model();
    @(posedge clk);
    #1;
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: act running exp finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R7"; compare();  // reset state all zero
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 straight, offset binary
    cur_req = "R1_R2_offset";
    cyc(16'h0000, 16'hFFFF, 1, 0);
    cyc(16'h8000, 16'h7FFF, 1, 0);
    for (int n = 0; n < 20; n++) cyc(16'(n * 16'h3A7 + 16'h1234), 16'(n * 16'h51F), 1, 0);
    // R2 two's complement passthrough
    twos = 1; cur_req = "R2_twos";
    cyc(16'h8000, 16'h0001, 1, 0);
    cyc(16'hFFFF, 16'h7FFF, 1, 0);
    // R3 reversal on B only
    rev_b = 1; cur_req = "R3";
    cyc(16'h0001, 16'h0001, 1, 0);
    cyc(16'h8000, 16'h8000, 1, 0);
    cyc(16'h1234, 16'h1234, 1, 0);
    twos = 0;
    cyc(16'h00F0, 16'h0003, 1, 0);
    rev_b = 0;
    // R6 txen low mid-stream
    cur_req = "R6";
    cyc(16'hAAAA, 16'h5555, 0, 0);
    cyc(16'h1111, 16'h2222, 1, 0);
    cyc(16'h3333, 16'h4444, 0, 0);

    // R4 edge-started interleave
    ilv = 1; qmode = 0; cur_req = "R4";
    for (int n = 0; n < 7; n++) cyc(16'(16'h0100 + n), 16'hDEAD, 1, 0);
    cyc(16'h0000, 16'h0000, 0, 0);
    for (int n = 0; n < 5; n++) cyc(16'(16'h0200 + n * 7), 16'hBEEF, 1, 1);
    // R6 txen drop with I pending
    cur_req = "R6_pend";
    cyc(16'h0300, 0, 1, 0);
    cyc(16'h0301, 0, 0, 0);
    cyc(16'h0302, 0, 1, 0);
    cyc(16'h0303, 0, 1, 0);

    // R5 flag mode
    qmode = 1; cur_req = "R5";
    cyc(16'h0400, 0, 0, 0);
    cyc(16'h0401, 0, 1, 1);  // lone Q dropped
    cyc(16'h0402, 0, 1, 1);
    cyc(16'h0403, 0, 1, 0);  // I
    cyc(16'h0404, 0, 1, 0);  // I replaces
    cyc(16'h0405, 0, 1, 1);  // pair 0404/0405
    cyc(16'h0406, 0, 1, 1);  // dropped
    for (int n = 0; n < 8; n++) cyc(16'(16'h0500 + n), 0, 1, n[0]);

    // R9 leaving interleave drops pending, controls act same edge
    cur_req = "R9";
    cyc(16'h0600, 16'h0700, 1, 0);  // I pending
    ilv = 0;
    cyc(16'h0601, 16'h0701, 1, 0);
    ilv = 1;
    cyc(16'h0602, 0, 1, 1);          // Q, no I -> dropped
    twos = 1;
    cyc(16'h0603, 0, 1, 0);
    twos = 0;
    cyc(16'h0604, 0, 1, 1);
    ilv = 0; qmode = 0;

    // R8 ramp incl. wrap
    ramp = 1; rev_b = 1; cur_req = "R8";
    for (int n = 0; n < 10; n++) cyc(16'hFFFF, 16'h1234, 1, 0);
    cyc(16'hFFFF, 16'h1234, 0, 0);
    for (int n = 0; n < 65536 + 4; n++) cyc(16'(n), 16'(~n), 1, 0);
    ramp = 0; rev_b = 0;
    cyc(16'h0000, 16'h0000, 1, 0);
    ramp = 1;
    for (int n = 0; n < 3; n++) cyc(16'h0000, 16'h0000, 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule